// File: doc/BRIEF.md
# Sequential Stage-Stepped Instruction Core

This block is a small 64-bit processor core for a byte-encoded teaching instruction set. It takes each instruction through six stages in strict order: fetch, decode, execute, memory, write-back and program-counter update. Every stage lasts one clock cycle, so each instruction takes six cycles. Three kinds of instruction advance the program counter:

- a one-byte no-op;
- a two-byte register-register arithmetic/logic operation;
- a ten-byte immediate add, which carries an eight-byte constant.

A halt code, or any code the core does not recognise, freezes the core and reports a status.

The core drives its program counter on an instruction-address port. The surrounding memory answers on the same cycle with the ten bytes that start at that address. The lowest byte lane holds the byte at the program counter. The core keeps sixteen 64-bit registers and three condition flags. Any register can be read at any time through a combinational observation port.

The stage controller is one enumerated state machine with these states:

- `S_FETCH` latches the decoded instruction, or goes to `S_STOP` on a halt or illegal code.
- `S_DECODE` reads both source registers.
- `S_EXECUTE` runs the ALU and updates the flags.
- `S_MEMORY` is an idle stage.
- `S_WRBACK` writes the result register.
- `S_PCUPD` advances the program counter and pulses the retire output.
- `S_STOP` absorbs all later cycles.

The state sequence is fixed: `S_FETCH→S_DECODE→S_EXECUTE→S_MEMORY→S_WRBACK→S_PCUPD→S_FETCH`, or `S_FETCH→S_STOP→S_STOP`.

Top module: `proc_seq_core`

## Requirements
- R1: After reset the program counter is 0, the status is 0 (running), the flags `cc_o` read 3'b100 (zero flag set, others clear) and all sixteen registers read 0.
- R2: The byte at PC gives the opcode in bits 7:4 and the function in bits 3:0. The byte at PC+1 gives the first register (rA) in bits 7:4 and the second register (rB) in bits 3:0. The constant is the eight bytes from PC+2 to PC+9 in little-endian order, so the byte at PC+2 is the least significant.
- R3: The program counter advances by the instruction length. A no-op (opcode 1, function 0) advances it by 1. A register operation (opcode 6) advances it by 2. An immediate add (opcode 0xC, function 0) advances it by 10.
- R4: A register operation writes rB ← rB op rA. The operation is add for function 0, subtract (rB − rA) for function 1, AND for function 2 and XOR for function 3. No other register changes.
- R5: An immediate add writes rB ← rB + constant.
- R6: `cc_o` is {zero, sign, overflow}. A register operation or an immediate add sets zero when the result is 0 and sets sign to result bit 63. Overflow is the two's-complement signed overflow for add and subtract, and 0 for AND and XOR. A no-op leaves the flags unchanged.
- R7: Each instruction passes through the six stages in order, one cycle each. `retire_o` is high for exactly one cycle, in the program-counter update stage, so it pulses once every six cycles.
- R8: Opcode 0 (halt, with any function) sets the status to 1. The program counter, flags and registers then stay frozen until reset.
- R9: Any other opcode outside {1, 6, 0xC} is illegal, and so is any of the following:
  - a register operation with function above 3;
  - a no-op with a non-zero function;
  - an immediate add with a non-zero function.

  An illegal instruction sets the status to 2 and freezes the core as in R8.
- R10: `obs_val` shows register `obs_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 64 | Byte address of the instruction being fetched (the program counter) |
| imem_data | input | 80 | Ten bytes starting at imem_addr; bits 7:0 hold the byte at imem_addr |
| obs_sel | input | 4 | Register index to observe |
| obs_val | output | 64 | Contents of register obs_sel |
| pc_o | output | 64 | Program counter |
| cc_o | output | 3 | Flags {zero, sign, overflow} |
| stat_o | output | 2 | 0 running, 1 halted, 2 illegal instruction |
| retire_o | output | 1 | High in the cycle an instruction completes |

## Verification
The bench goes after several corner cases:

- Signed overflow at both ends: a maximum positive value plus one, and zero minus the most negative value. A core that ignored overflow, or swapped the subtract operands, would show the wrong sign of the result and wrong flags.
- Self-XOR and disjoint AND, which give zero results. A core that took the zero flag from the wrong operand would miss these.
- A scrambled constant, used to expose byte-order mistakes.
- Random mixes with the same register as source and target, and with length-1, length-2 and length-10 instructions interleaved. A core that used the wrong length would fetch garbage and diverge.
- Halt and illegal codes, including a bad function on a legal opcode. The bench holds the core there and checks that nothing moves; a core that kept stepping would change the program counter.

// File: rtl/proc_pkg.sv
package proc_pkg;
    localparam int WORD_W      = 64;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int FETCH_BYTES = 2 + WORD_BYTES;
    localparam int FETCH_W     = 8 * FETCH_BYTES;
    localparam int NREG        = 16;
    localparam int REG_IW      = $clog2(NREG);
    localparam int LEN_W       = 4;

    localparam logic [3:0] OPC_HALT = 4'h0;
    localparam logic [3:0] OPC_NOP  = 4'h1;
    localparam logic [3:0] OPC_ALU  = 4'h6;
    localparam logic [3:0] OPC_IMM  = 4'hC;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_HLT = 2'd1,
        ST_INS = 2'd2
    } run_stat_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXECUTE,
        S_MEMORY,
        S_WRBACK,
        S_PCUPD,
        S_STOP
    } stage_e;

    typedef struct packed {
        logic [REG_IW-1:0] ra;
        logic [REG_IW-1:0] rb;
        logic [WORD_W-1:0] valc;
        logic [LEN_W-1:0]  len;
        logic              uses_alu;
        logic              use_const;
        alu_fn_e           fn;
    } instr_t;
endpackage

// File: rtl/proc_fetch_decode.sv
module proc_fetch_decode
    import proc_pkg::*;
(
    input  logic [FETCH_W-1:0] fetch_bytes,
    output instr_t             ins,
    output logic               legal,
    output logic               is_halt
);
    logic [3:0] opc;
    logic [3:0] fun;

    assign opc = fetch_bytes[7:4];
    assign fun = fetch_bytes[3:0];

    always_comb begin
        ins.ra        = fetch_bytes[15:12];
        ins.rb        = fetch_bytes[11:8];
        ins.valc      = fetch_bytes[FETCH_W-1:16];
        ins.len       = LEN_W'(1);
        ins.uses_alu  = 1'b0;
        ins.use_const = 1'b0;
        ins.fn        = FN_ADD;
        legal         = 1'b0;
        is_halt       = 1'b0;
        case (opc)
            OPC_HALT: begin
                is_halt = 1'b1;
            end
            OPC_NOP: begin
                legal = (fun == 4'h0);
            end
            OPC_ALU: begin
                legal        = (fun[3:2] == 2'b00);
                ins.len      = LEN_W'(2);
                ins.uses_alu = 1'b1;
                ins.fn       = alu_fn_e'(fun[1:0]);
            end
            OPC_IMM: begin
                legal         = (fun == 4'h0);
                ins.len       = LEN_W'(FETCH_BYTES);
                ins.uses_alu  = 1'b1;
                ins.use_const = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/proc_alu.sv
module proc_alu
    import proc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res,
    output logic         zf,
    output logic         sf,
    output logic         of
);
    always_comb begin
        of = 1'b0;
        unique case (fn)
            FN_ADD: begin
                res = opb + opa;
                of  = (opa[W-1] == opb[W-1]) && (res[W-1] != opb[W-1]);
            end
            FN_SUB: begin
                res = opb - opa;
                of  = (opa[W-1] != opb[W-1]) && (res[W-1] != opb[W-1]);
            end
            FN_AND:  res = opb & opa;
            FN_XOR:  res = opb ^ opa;
            default: res = '0;
        endcase
        zf = (res == '0);
        sf = res[W-1];
    end
endmodule

// File: rtl/proc_regfile.sv
module proc_regfile
    import proc_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = WORD_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a_val,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b_val,
    input  logic [IW-1:0] obs_idx,
    output logic [W-1:0]  obs_val,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] rf_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rf_q[i] <= '0;
        end else if (wr_en) begin
            rf_q[wr_idx] <= wr_data;
        end
    end

    assign rd_a_val = rf_q[rd_a_idx];
    assign rd_b_val = rf_q[rd_b_idx];
    assign obs_val  = rf_q[obs_idx];

    // R4
    rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rf_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/proc_seq_core.sv
module proc_seq_core
    import proc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [WORD_W-1:0]    imem_addr,
    input  logic [FETCH_W-1:0]   imem_data,
    input  logic [REG_IW-1:0]    obs_sel,
    output logic [WORD_W-1:0]    obs_val,
    output logic [WORD_W-1:0]    pc_o,
    output logic [2:0]           cc_o,
    output logic [1:0]           stat_o,
    output logic                 retire_o
);
    stage_e            state_q, state_d;
    run_stat_e         stat_q;
    instr_t            dec_ins, ir_q;
    logic              dec_legal, dec_halt;
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] vala_q, valb_q, vale_q;
    logic [WORD_W-1:0] rd_a, rd_b;
    logic [WORD_W-1:0] alu_a, alu_res;
    logic              alu_zf, alu_sf, alu_of;
    logic [2:0]        cc_q;

    // stage control strobes (output process)
    logic              do_latch_ir, do_read, do_exec, do_wb, do_pc;

    proc_fetch_decode u_dec (
        .fetch_bytes (imem_data),
        .ins         (dec_ins),
        .legal       (dec_legal),
        .is_halt     (dec_halt)
    );

    proc_regfile #(.N(NREG), .W(WORD_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ir_q.ra),
        .rd_a_val (rd_a),
        .rd_b_idx (ir_q.rb),
        .rd_b_val (rd_b),
        .obs_idx  (obs_sel),
        .obs_val  (obs_val),
        .wr_en    (do_wb),
        .wr_idx   (ir_q.rb),
        .wr_data  (vale_q)
    );

    assign alu_a = ir_q.use_const ? ir_q.valc : vala_q;

    proc_alu #(.W(WORD_W)) u_alu (
        .fn  (ir_q.fn),
        .opa (alu_a),
        .opb (valb_q),
        .res (alu_res),
        .zf  (alu_zf),
        .sf  (alu_sf),
        .of  (alu_of)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // next-state and stage strobes
    always_comb begin
        state_d     = state_q;
        do_latch_ir = 1'b0;
        do_read     = 1'b0;
        do_exec     = 1'b0;
        do_wb       = 1'b0;
        do_pc       = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                do_latch_ir = 1'b1;
                state_d     = dec_legal ? S_DECODE : S_STOP;
            end
            S_DECODE: begin
                do_read = 1'b1;
                state_d = S_EXECUTE;
            end
            S_EXECUTE: begin
                do_exec = ir_q.uses_alu;
                state_d = S_MEMORY;
            end
            S_MEMORY: begin
                state_d = S_WRBACK;
            end
            S_WRBACK: begin
                do_wb   = ir_q.uses_alu;
                state_d = S_PCUPD;
            end
            S_PCUPD: begin
                do_pc   = 1'b1;
                state_d = S_FETCH;
            end
            S_STOP: begin
                state_d = S_STOP;
            end
            default: state_d = S_STOP;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            stat_q <= ST_RUN;
            ir_q   <= '0;
            vala_q <= '0;
            valb_q <= '0;
            vale_q <= '0;
            cc_q   <= 3'b100;
        end else begin
            if (do_latch_ir) begin
                ir_q <= dec_ins;
                if (!dec_legal) stat_q <= dec_halt ? ST_HLT : ST_INS;
            end
            if (do_read) begin
                vala_q <= rd_a;
                valb_q <= rd_b;
            end
            if (do_exec) begin
                vale_q <= alu_res;
                cc_q   <= {alu_zf, alu_sf, alu_of};
            end
            if (do_pc) pc_q <= pc_q + WORD_W'(ir_q.len);
        end
    end

    assign imem_addr = pc_q;
    assign pc_o      = pc_q;
    assign cc_o      = cc_q;
    assign stat_o    = stat_q;
    assign retire_o  = (state_q == S_PCUPD);

    // R7
    stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXECUTE) |=> (state_q == S_MEMORY));
    // R7
    retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> !retire_o);
    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> ((pc_o == $past(pc_o) + 64'd1) || (pc_o == $past(pc_o) + 64'd2)
                      || (pc_o == $past(pc_o) + 64'd10)));
    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o != 2'd0) |=> ($stable(pc_o) && $stable(cc_o) && $stable(stat_o)));
    // R6
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_EXECUTE) |=> $stable(cc_q));
endmodule

// File: tb/proc_seq_core_tb.sv
`timescale 1ns/1ps
module proc_seq_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] imem_addr, obs_val, pc_o;
    logic [79:0] imem_data;
    logic [3:0]  obs_sel = 4'd0;
    logic [2:0]  cc_o;
    logic [1:0]  stat_o;
    logic        retire_o;

    always #4 clk = ~clk;

    logic [7:0] mem [0:1023];
    always_comb begin
        for (int k = 0; k < 10; k++)
            imem_data[8*k +: 8] = mem[10'(imem_addr[9:0] + 10'(k))];
    end

    proc_seq_core u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .obs_sel(obs_sel), .obs_val(obs_val), .pc_o(pc_o), .cc_o(cc_o),
        .stat_o(stat_o), .retire_o(retire_o)
    );

    int checks = 0;
    int errors = 0;

    // program list: kind 0 nop, 1 reg op, 2 immediate add
    int          n_ins;
    int          wp;
    int          p_kind [0:63];
    int          p_fn   [0:63];
    int          p_ra   [0:63];
    int          p_rb   [0:63];
    logic [63:0] p_imm  [0:63];

    logic [63:0] exp_reg [0:15];
    logic [63:0] exp_pc;
    logic [2:0]  exp_cc;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [63:0] v);
        obs_sel = 4'(idx);
        #1;
        v = obs_val;
    endtask

    function automatic logic [66:0] alu_ref(input int fn, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic        o;
        o = 1'b0;
        case (fn)
            0: begin r = b + a; o = (a[63] == b[63]) && (r[63] != b[63]); end
            1: begin r = b - a; o = (a[63] != b[63]) && (r[63] != b[63]); end
            2: r = b & a;
            default: r = b ^ a;
        endcase
        return {(r == 64'd0), r[63], o, r};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        wp = 0;
        n_ins = 0;
    endtask

    task automatic emit_raw(input logic [7:0] b);
        mem[wp] = b;
        wp++;
    endtask

    task automatic emit_nop();
        p_kind[n_ins] = 0; n_ins++;
        emit_raw(8'h10);
    endtask

    task automatic emit_alu(input int fn, input int ra, input int rb);
        p_kind[n_ins] = 1; p_fn[n_ins] = fn; p_ra[n_ins] = ra; p_rb[n_ins] = rb; n_ins++;
        emit_raw({4'h6, 4'(fn)});
        emit_raw({4'(ra), 4'(rb)});
    endtask

    task automatic emit_imm(input int rb, input logic [63:0] v);
        p_kind[n_ins] = 2; p_ra[n_ins] = 15; p_rb[n_ins] = rb; p_imm[n_ins] = v; n_ins++;
        emit_raw(8'hC0);
        emit_raw({4'hF, 4'(rb)});
        for (int i = 0; i < 8; i++) emit_raw(v[8*i +: 8]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) exp_reg[i] = 64'd0;
        exp_pc = 64'd0;
        exp_cc = 3'b100;
    endtask

    task automatic run_prog();
        logic [63:0] v;
        logic [66:0] r;
        for (int i = 0; i < n_ins; i++) begin
            int cyc = 0;
            do begin
                @(negedge clk);
                cyc++;
            end while (!retire_o && cyc < 40);
            chk(cyc == 5, "R7 retire spacing", 64'(cyc), 64'd5);
            @(negedge clk);
            case (p_kind[i])
                0: exp_pc = exp_pc + 64'd1;
                1: begin
                    r = alu_ref(p_fn[i], exp_reg[p_ra[i]], exp_reg[p_rb[i]]);
                    exp_reg[p_rb[i]] = r[63:0];
                    exp_cc = r[66:64];
                    exp_pc = exp_pc + 64'd2;
                end
                default: begin
                    r = alu_ref(0, p_imm[i], exp_reg[p_rb[i]]);
                    exp_reg[p_rb[i]] = r[63:0];
                    exp_cc = r[66:64];
                    exp_pc = exp_pc + 64'd10;
                end
            endcase
            chk(pc_o == exp_pc, "R3 pc advance", pc_o, exp_pc);
            chk(cc_o == exp_cc, "R6 flags", 64'(cc_o), 64'(exp_cc));
            if (p_kind[i] != 0) begin
                read_reg(p_rb[i], v);
                chk(v == exp_reg[p_rb[i]], p_kind[i] == 1 ? "R4 reg op result" : "R5 R2 immediate result",
                    v, exp_reg[p_rb[i]]);
                read_reg(p_ra[i], v);
                chk(v == exp_reg[p_ra[i]], "R4 R10 other register", v, exp_reg[p_ra[i]]);
            end
        end
    endtask

    task automatic expect_stop(input logic [1:0] st, input string req);
        logic [63:0] v;
        int cyc = 0;
        while (stat_o == 2'd0 && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(stat_o == st, req, 64'(stat_o), 64'(st));
        chk(pc_o == exp_pc, req, pc_o, exp_pc);
        repeat (12) @(negedge clk);
        chk(pc_o == exp_pc && stat_o == st, req, pc_o, exp_pc);
        chk(cc_o == exp_cc, req, 64'(cc_o), 64'(exp_cc));
        chk(retire_o == 1'b0, req, 64'(retire_o), 64'd0);
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            chk(v == exp_reg[i], req, v, exp_reg[i]);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h1234abcd));

        // phase 1: directed corners
        clear_prog();
        emit_imm(1, 64'h7fff_ffff_ffff_ffff);
        emit_imm(2, 64'd1);
        emit_alu(0, 2, 1);           // max + 1: overflow, sign
        emit_alu(1, 1, 3);           // 0 - min: overflow
        emit_alu(3, 3, 3);           // self xor -> zero
        emit_imm(5, 64'h00ff_00ff_00ff_00ff);
        emit_alu(2, 1, 2);           // disjoint and -> zero
        emit_nop();
        emit_imm(15, 64'hffff_ffff_ffff_ffff);
        emit_imm(4, 64'h0123_4567_89ab_cdef); // R2 byte order
        emit_alu(1, 4, 4);           // same register subtract -> zero
        emit_raw(8'h00);
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(pc_o == 64'd0, "R1 pc", pc_o, 64'd0);
        chk(stat_o == 2'd0, "R1 stat", 64'(stat_o), 64'd0);
        chk(cc_o == 3'b100, "R1 flags", 64'(cc_o), 64'd4);
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            chk(v == 64'd0, "R1 register zero", v, 64'd0);
        end
        do_reset();
        run_prog();
        read_reg(4, v);
        chk(v == 64'd0, "R4 subtract self", v, 64'd0);
        expect_stop(2'd1, "R8 halt freeze");

        // phase 2: random mix ending in a bad function code
        clear_prog();
        for (int i = 0; i < 40; i++) begin
            int kd = int'($urandom_range(0, 9));
            int ra = int'($urandom_range(0, 15));
            int rb = int'($urandom_range(0, 15));
            if (kd == 0) emit_nop();
            else if (kd < 6) emit_alu(int'($urandom_range(0, 3)), ra, rb);
            else begin
                logic [63:0] imm;
                imm = {$urandom, $urandom};
                if (kd == 9) imm = 64'h8000_0000_0000_0000;
                emit_imm(rb, imm);
            end
        end
        emit_raw(8'h65);
        emit_raw(8'h12);
        do_reset();
        run_prog();
        expect_stop(2'd2, "R9 bad function");

        // phase 3: unknown opcode
        clear_prog();
        emit_raw(8'h90);
        do_reset();
        expect_stop(2'd2, "R9 unknown opcode");

        // phase 4: nop with non-zero function
        clear_prog();
        emit_nop();
        emit_raw(8'h12);
        do_reset();
        run_prog();
        expect_stop(2'd2, "R9 nop function");

        // phase 5: halt with non-zero function
        clear_prog();
        emit_imm(7, 64'd42);
        emit_raw(8'h07);
        do_reset();
        run_prog();
        expect_stop(2'd1, "R8 halt any function");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule